// File: doc/BRIEF.md
# E1 Far-End Block Error and Line Violation Counter

This block counts error events for an E1 receiver. In error-indication mode it watches bit 1 of time slot 0. In frames 13 and 15 of a CRC-4 multiframe that bit carries the far end's report of a failed block check on the signal this side transmits. Every zero seen there adds one to the count. The result therefore describes the quality of the outgoing transmit line as the remote end sees it. In line mode the same counter counts code-violation pulses that an external line decoder supplies.

The counter is 8 bits wide by default. A configuration bit widens it to 10 bits, and the two upper bits are read on their own status pins. The count stops at the largest value the selected width can hold. A snapshot strobe copies the live count into a read register and restarts the count for the next interval. Line decoding and multiframe alignment take place elsewhere. Their results reach this block as a frame number, a frame strobe and a lock flag.

All inputs are plain control and status pins sampled on the rising clock edge. Events are single-cycle pulses and cannot be held back, so the block has no valid/ready handshake and no back-pressure.

Top module: `e1_err_counter`

## Requirements
- R1: After reset, both the live count and the read register (`snap_count`, `snap_ext`) are zero.
- R2: With `cfg_si_mode`=1, one count is added for each cycle in which all of these hold: `ts0_valid`=1, `mf_locked`=1, `ts0_bit1`=0, and `frm_num` (4-bit multiframe position 0..15) equal to 13 or 15.
- R3: With `cfg_si_mode`=1, nothing is counted for other frame numbers, for `ts0_bit1`=1, while `mf_locked`=0, while `ts0_valid`=0, or from `cv_pulse`.
- R4: With `cfg_si_mode`=0, each cycle with `cv_pulse`=1 adds one count, and the time-slot-0 inputs have no effect.
- R5: With `cfg_wide`=0 the count saturates at 255. With `cfg_wide`=1 it saturates at 1023. It never wraps.
- R6: `snap_count` holds bits 7:0 of the captured count, and `snap_ext` holds bits 9:8, which are always zero for a count taken in 8-bit width.
- R7: A cycle with `snap`=1 loads the read register with the count reached before that cycle and restarts the live count. An event in that same cycle becomes the first count of the new interval. The read register changes only on `snap`.
- R8: Any change of `cfg_si_mode` or `cfg_wide` clears the live count, and an event in the cycle of the change is dropped.
- R9: The live count grows by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_si_mode | input | 1 | 1 = count far-end error bits, 0 = count line violations |
| cfg_wide | input | 1 | 1 = 10-bit counter, 0 = 8-bit counter |
| ts0_valid | input | 1 | Strobe: time-slot-0 bit 1 of the current frame is present |
| frm_num | input | 4 | Frame position within the CRC-4 multiframe |
| ts0_bit1 | input | 1 | Value of time-slot-0 bit 1 |
| mf_locked | input | 1 | Multiframe alignment held |
| cv_pulse | input | 1 | One-cycle code-violation pulse from the line decoder |
| snap | input | 1 | Capture the count and restart it |
| snap_count | output | 8 | Captured count, bits 7:0 |
| snap_ext | output | 2 | Captured count, bits 9:8 |

## Verification
On every cycle the assertions check the following:
- a clear always leaves the count at zero;
- the count rises by at most one per cycle and never passes the 8-bit limit;
- a restart leaves exactly the same-cycle event;
- the read register holds its value between snapshots;
- an unlocked stream or an idle violation input never produces an event.

Only the bench scenarios can show the rest:
- that the exact set of frames, bit values and lock states counts, which the bench confirms by sweeping all of them;
- where saturation sets in at each width;
- how the captured value splits between the low byte and the extension bits;
- what happens when an event coincides with a snapshot or with a configuration change.

// File: rtl/e1ec_pkg.sv
package e1ec_pkg;
  localparam int FRM_W    = 4;
  localparam int BASE_W   = 8;
  localparam int EXT_W    = 2;
  localparam int FULL_W   = BASE_W + EXT_W;
  localparam int SI_FRM_A = 13;
  localparam int SI_FRM_B = 15;

  typedef enum logic {
    MODE_LINE_CV = 1'b0,
    MODE_SI_ZERO = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/e1ec_event_qual.sv
module e1ec_event_qual
  import e1ec_pkg::*;
#(
  parameter int FW   = FRM_W,
  parameter int FRMA = SI_FRM_A,
  parameter int FRMB = SI_FRM_B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cnt_mode_e     mode,
  input  logic          ts0_valid,
  input  logic [FW-1:0] frm_num,
  input  logic          ts0_bit1,
  input  logic          mf_locked,
  input  logic          cv_pulse,
  output logic          evt
);
  localparam logic [FW-1:0] FA = FW'(FRMA);
  localparam logic [FW-1:0] FB = FW'(FRMB);

  logic frame_hit;
  logic si_zero;

  always_comb begin
    frame_hit = (frm_num == FA) || (frm_num == FB);
    si_zero   = ts0_valid && mf_locked && !ts0_bit1 && frame_hit;
    case (mode)
      MODE_SI_ZERO: evt = si_zero;
      default:      evt = cv_pulse;
    endcase
  end

  // R3: an unaligned stream never yields an error-bit event
  p_unlocked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SI_ZERO && !mf_locked) |-> !evt);
  // R4: in line mode no event without a violation pulse
  p_cv_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LINE_CV && !cv_pulse) |-> !evt);
endmodule

// File: rtl/e1ec_sat_counter.sv
module e1ec_sat_counter
  import e1ec_pkg::*;
#(
  parameter int NW = BASE_W,
  parameter int WW = FULL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          inc,
  input  logic          clr,
  input  logic          restart,
  output logic [WW-1:0] cnt
);
  localparam logic [WW-1:0] MAX_WIDE   = {WW{1'b1}};
  localparam logic [WW-1:0] MAX_NARROW = WW'((1 << NW) - 1);

  logic [WW-1:0] limit;
  logic          at_limit;

  always_comb begin
    limit    = wide ? MAX_WIDE : MAX_NARROW;
    at_limit = (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (restart)           cnt <= WW'(inc);
    else if (inc && !at_limit)  cnt <= cnt + 1'b1;
  end

  // R8: a clear always lands at zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R9: never more than one step per cycle, never backwards
  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !restart) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
  // R5: narrow width stays within 8 bits
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !clr) |=> (cnt <= MAX_NARROW));
  // R7: restart keeps only the same-cycle event
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !clr) |=> (cnt == WW'($past(inc))));
endmodule

// File: rtl/e1ec_snapshot.sv
module e1ec_snapshot
  import e1ec_pkg::*;
#(
  parameter int WW = FULL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snap,
  input  logic [WW-1:0] live,
  output logic [WW-1:0] held
);
  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (snap) held <= live;
  end

  // R7: the read register moves only on a snapshot
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(held));
endmodule

// File: rtl/e1_err_counter.sv
module e1_err_counter
  import e1ec_pkg::*;
#(
  parameter int FW = FRM_W,
  parameter int NW = BASE_W,
  parameter int XW = EXT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_si_mode,
  input  logic          cfg_wide,
  input  logic          ts0_valid,
  input  logic [FW-1:0] frm_num,
  input  logic          ts0_bit1,
  input  logic          mf_locked,
  input  logic          cv_pulse,
  input  logic          snap,
  output logic [NW-1:0] snap_count,
  output logic [XW-1:0] snap_ext
);
  localparam int WW = NW + XW;

  cnt_mode_e     mode;
  logic          mode_q;
  logic          wide_q;
  logic          cfg_chg;
  logic          evt;
  logic [WW-1:0] live_cnt;
  logic [WW-1:0] held_cnt;

  assign mode = cnt_mode_e'(cfg_si_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      mode_q <= cfg_si_mode;
      wide_q <= cfg_wide;
    end
  end

  assign cfg_chg = (mode_q != cfg_si_mode) || (wide_q != cfg_wide);

  e1ec_event_qual #(.FW(FW)) qual_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ts0_valid(ts0_valid),
    .frm_num(frm_num), .ts0_bit1(ts0_bit1), .mf_locked(mf_locked),
    .cv_pulse(cv_pulse), .evt(evt)
  );

  e1ec_sat_counter #(.NW(NW), .WW(WW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .inc(evt),
    .clr(cfg_chg), .restart(snap), .cnt(live_cnt)
  );

  e1ec_snapshot #(.WW(WW)) snap_i (
    .clk(clk), .rst_n(rst_n), .snap(snap), .live(live_cnt), .held(held_cnt)
  );

  assign snap_count = held_cnt[NW-1:0];
  assign snap_ext   = held_cnt[WW-1:NW];

  // R6: a capture taken in narrow width has empty extension bits
  p_ext_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snap && !cfg_wide && !wide_q) |=> (snap_ext == '0));
endmodule

// File: tb/e1_err_counter_tb.sv
module e1_err_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_si_mode = 1'b1, cfg_wide = 1'b0;
  logic       ts0_valid = 1'b0, ts0_bit1 = 1'b1, mf_locked = 1'b0;
  logic [3:0] frm_num = '0;
  logic       cv_pulse = 1'b0, snap = 1'b0;
  logic [7:0] snap_count;
  logic [1:0] snap_ext;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  e1_err_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_si_mode(cfg_si_mode), .cfg_wide(cfg_wide),
    .ts0_valid(ts0_valid), .frm_num(frm_num), .ts0_bit1(ts0_bit1),
    .mf_locked(mf_locked), .cv_pulse(cv_pulse), .snap(snap),
    .snap_count(snap_count), .snap_ext(snap_ext)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_snap(bit with_cv);
    snap = 1'b1; cv_pulse = with_cv; tick();
    snap = 1'b0; cv_pulse = 1'b0;
  endtask

  function automatic int rd();
    return {snap_ext, snap_count};
  endfunction

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin cv_pulse = 1'b1; tick(); end
    cv_pulse = 1'b0;
  endtask

  initial begin
    int exp_si;
    repeat (3) tick();
    rst_n = 1'b1; tick();
    check("R1 reset count", rd(), 0);

    // R2/R3 sweep: every lock state, bit value and frame, cv pulses present
    exp_si = 0;
    for (int lk = 0; lk < 2; lk++)
      for (int b = 0; b < 2; b++)
        for (int f = 0; f < 16; f++) begin
          mf_locked = lk[0]; ts0_bit1 = b[0]; frm_num = 4'(f);
          ts0_valid = 1'b1; cv_pulse = 1'b1; tick();
          ts0_valid = 1'b0; ts0_bit1 = 1'b0; tick();
          if (lk == 1 && b == 0 && (f == 13 || f == 15)) exp_si++;
        end
    cv_pulse = 1'b0;
    do_snap(1'b0);
    check("R2/R3 sweep", rd(), exp_si);
    for (int m = 0; m < 40; m++)
      for (int f = 0; f < 16; f++) begin
        mf_locked = 1'b1; ts0_bit1 = 1'b0; frm_num = 4'(f); ts0_valid = 1'b1; tick();
      end
    ts0_valid = 1'b0;
    repeat (5) tick();
    check("R7 read holds", rd(), exp_si);
    do_snap(1'b0);
    check("R2 locked multiframes", rd(), 80);
    do_snap(1'b0);
    check("R7 restart empty", rd(), 0);

    // R4 line mode; mode change clears
    cfg_si_mode = 1'b0; tick();
    for (int i = 0; i < 37; i++) begin
      cv_pulse = 1'b1; ts0_valid = 1'b1; frm_num = 4'd13; ts0_bit1 = 1'b0; tick();
      cv_pulse = 1'b0; tick();
    end
    ts0_valid = 1'b0;
    do_snap(1'b0);
    check("R4 violations", rd(), 37);

    pulses(5);
    do_snap(1'b1);
    check("R7 value before snap cycle", rd(), 5);
    do_snap(1'b0);
    check("R7 same-cycle event kept", rd(), 1);

    pulses(300);
    do_snap(1'b0);
    check("R5 narrow saturation", rd(), 255);
    check("R6 ext zero narrow", snap_ext, 0);

    cfg_wide = 1'b1; tick();
    pulses(700);
    do_snap(1'b0);
    check("R6 low byte", snap_count, 700 % 256);
    check("R6 ext bits", snap_ext, 2);
    pulses(1100);
    do_snap(1'b0);
    check("R5 wide saturation", rd(), 1023);

    pulses(20);
    cfg_wide = 1'b0; cv_pulse = 1'b1; tick();
    cv_pulse = 1'b0;
    pulses(3);
    do_snap(1'b0);
    check("R8 width change clears", rd(), 3);
    pulses(9);
    cfg_si_mode = 1'b1; tick();
    cfg_si_mode = 1'b0; tick();
    do_snap(1'b0);
    check("R8 mode change clears", rd(), 0);

    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    check("R1 reset clears read", rd(), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule